// File: doc/BRIEF.md
# External Interrupt Detect Unit

This block turns two active-low external interrupt pins into interrupt requests for a controller core. The core runs a machine cycle of twelve oscillator clocks, divided into six states (S1 to S6) of two clocks each. An internal sequencer marks each state, and the request flags move only at fixed points inside that cycle.

Each pin has a type bit in an 8-bit control register. With the type bit at 0 the input is level-sensed. The pin is sampled at S5, the sample becomes the request flag at the next S3, and the flag is dropped again at S6. A pin held low therefore gives a request that is renewed once per machine cycle. With the type bit at 1 the input is edge-sensed. A high sample followed by a low sample raises the flag, and the flag stays raised until the interrupt controller acknowledges it or software writes it to zero.

The same register also holds four timer-related bits. This block only stores them. Software writes and reads the whole register through one data port.

Top module: `ext_irq_detect`

## Requirements
- R1: `state_oh` is one-hot. Bit 0 is S1 and bit 5 is S6. After reset it shows S1, and each state lasts exactly two clocks before moving to the next, wrapping from S6 back to S1 (12 clocks per machine cycle).
- R2: While `rst` is high, `reg_rdata` is 0, `req` is 0 and `state_oh` is 6'b000001. Every internal sample and pending bit is cleared.
- R3: Control register layout: bit 0 is the type of input 0 (1 = edge), bit 1 is the request flag of input 0, bit 2 is the type of input 1, and bit 3 is the request flag of input 1. Bits 7..4 only store what is written. A write with `reg_we` high stores all eight bits, and `reg_rdata` shows them from the next cycle on.
- R4: Each pin passes through a two-flop synchronizer. The level seen at the S5 sampling edge is the pin level captured two clock edges earlier. A pin that falls one edge too late for this is seen in the following machine cycle.
- R5: Level mode: a low sample at the first clock of S5 sets the flag at the first clock of the next S3. A high sample leaves it clear.
- R6: Level mode: the flag is cleared at the first clock of S6 in every machine cycle, so the request is high only from S3 to S5.
- R7: Edge mode: a high S5 sample followed by a low S5 sample sets the flag at the next S3. The flag is not cleared at S6, and a pin that stays low does not set it again.
- R8: A flag set in edge mode is cleared by a one-clock pulse on the matching `ack` bit, or by a register write with that flag bit at 0.
- R9: Flag update order within one clock: write, then acknowledge clear, then S6 clear (level mode), then S3 set. A set at S3 wins over an ack or a write of 0 in the same clock, and an S6 clear wins over a write of 1.
- R10: `req[0]` equals register bit 1 and `req[1]` equals register bit 3 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 2 | Active-low external interrupt pins, asynchronous |
| ack | input | 2 | Acknowledge pulse per input, clears that request flag |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| req | output | 2 | Request flags to the interrupt controller |
| state_oh | output | 6 | One-hot machine-cycle state, bit 0 = S1 |

## Verification
In level mode, long low and high holds show the flag pulsing from S3 to S6 and then staying quiet. A pin that falls one clock too late for the S5 sample separates correct synchronizer latency from an off-by-one. In edge mode, a pin that falls and then stays low shows that a latched flag persists and does not re-trigger, unlike level mode. Acks and register writes placed exactly on the S3 and S6 clocks check the update order, and a long stretch of pseudo-random pin holds, acks and mode changes is compared against the reference model on every clock.

// File: rtl/eid_pkg.sv
`timescale 1ns/1ps
package eid_pkg;
  localparam int REG_BITS   = 8;
  localparam int CYC_STATES = 6;
  localparam int SET_STATE  = 2;  // S3
  localparam int SMP_STATE  = 4;  // S5
  localparam int CLR_STATE  = 5;  // S6
  localparam logic [REG_BITS-1:0] PLAIN_BITS = 8'hF5;

  function automatic int type_pos(input int ch);
    return 2 * ch;
  endfunction

  function automatic int flag_pos(input int ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/eid_seq.sv
`timescale 1ns/1ps
module eid_seq #(
  parameter int STATES        = 6,
  parameter int CLK_PER_STATE = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STATES-1:0] state_oh,
  output logic [STATES-1:0] state_first
);
  localparam int TOTAL = STATES * CLK_PER_STATE;
  localparam int CW    = $clog2(TOTAL);

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_nx;
  logic [STATES-1:0] oh_nx;
  logic [STATES-1:0] first_nx;

  always_comb begin
    cnt_nx = (cnt_q == CW'(TOTAL - 1)) ? '0 : cnt_q + CW'(1);
    for (int i = 0; i < STATES; i++) begin
      oh_nx[i]    = (int'(cnt_nx) >= i * CLK_PER_STATE) &&
                    (int'(cnt_nx) < (i + 1) * CLK_PER_STATE);
      first_nx[i] = (int'(cnt_nx) == i * CLK_PER_STATE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      state_oh    <= {{(STATES-1){1'b0}}, 1'b1};
      state_first <= {{(STATES-1){1'b0}}, 1'b1};
    end else begin
      cnt_q       <= cnt_nx;
      state_oh    <= oh_nx;
      state_first <= first_nx;
    end
  end
endmodule

// File: rtl/eid_sync.sv
`timescale 1ns/1ps
module eid_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/eid_ctrl.sv
`timescale 1ns/1ps
module eid_ctrl #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & KEEP;
  end
endmodule

// File: rtl/eid_channel.sv
`timescale 1ns/1ps
module eid_channel (
  input  logic clk,
  input  logic rst,
  input  logic pin_lvl,
  input  logic edge_mode,
  input  logic smp_stb,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  logic lvl_pend;
  logic edge_pend;
  logic prev_hi;
  logic flag_nx;

  always_comb begin
    flag_nx = wr_en ? wr_val : flag;
    if (ack) flag_nx = 1'b0;
    if (!edge_mode && clr_stb) flag_nx = 1'b0;
    if (set_stb && (edge_mode ? edge_pend : lvl_pend)) flag_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_pend  <= 1'b0;
      edge_pend <= 1'b0;
      prev_hi   <= 1'b1;
      flag      <= 1'b0;
    end else begin
      flag <= flag_nx;
      if (smp_stb) begin
        lvl_pend  <= ~pin_lvl;
        edge_pend <= prev_hi & ~pin_lvl;
        prev_hi   <= pin_lvl;
      end
    end
  end
endmodule

// File: rtl/ext_irq_detect.sv
`timescale 1ns/1ps
module ext_irq_detect
  import eid_pkg::*;
#(
  parameter int N_IRQ         = 2,
  parameter int STATES        = CYC_STATES,
  parameter int CLK_PER_STATE = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          irq_n,
  input  logic [1:0]          ack,
  input  logic                reg_we,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic [1:0]          req,
  output logic [5:0]          state_oh
);
  logic [STATES-1:0]   stb_first;
  logic [STATES-1:0]   stb_oh;
  logic [REG_BITS-1:0] ctrl_q;

  eid_seq #(.STATES(STATES), .CLK_PER_STATE(CLK_PER_STATE)) u_seq (
    .clk(clk), .rst(rst), .state_oh(stb_oh), .state_first(stb_first)
  );

  assign state_oh = stb_oh;

  eid_ctrl #(.W(REG_BITS), .KEEP(PLAIN_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .q(ctrl_q)
  );

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ch
    logic pin_s;

    eid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(irq_n[g]), .q(pin_s)
    );

    eid_channel u_chan (
      .clk(clk), .rst(rst), .pin_lvl(pin_s),
      .edge_mode(ctrl_q[type_pos(g)]),
      .smp_stb(stb_first[SMP_STATE]),
      .set_stb(stb_first[SET_STATE]),
      .clr_stb(stb_first[CLR_STATE]),
      .ack(ack[g]), .wr_en(reg_we), .wr_val(reg_wdata[flag_pos(g)]),
      .flag(req[g])
    );
  end

  always_comb begin
    reg_rdata = ctrl_q;
    for (int c = 0; c < N_IRQ; c++) reg_rdata[flag_pos(c)] = req[c];
  end
endmodule

// File: rtl/eid_checker.sv
`timescale 1ns/1ps
module eid_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] state_oh,
  input logic [5:0] first,
  input logic [1:0] req,
  input logic [7:0] rdata,
  input logic [1:0] ack,
  input logic       reg_we
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);

  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    (past_ok && state_oh != $past(state_oh)) |->
      state_oh == {$past(state_oh[4:0]), $past(state_oh[5])});

  a_r6_clear0: assert property (@(posedge clk) disable iff (rst)
    (first[5] && !rdata[0]) |=> !req[0]);

  a_r6_clear1: assert property (@(posedge clk) disable iff (rst)
    (first[5] && !rdata[2]) |=> !req[1]);

  a_r5_set_at_s3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(req[0])) |-> ($past(first[2]) || $past(reg_we)));

  a_r7_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (req[1] && rdata[2] && !ack[1] && !reg_we) |=> req[1]);

  a_r10_mirror: assert property (@(posedge clk) disable iff (rst)
    req == {rdata[3], rdata[1]});
endmodule

bind ext_irq_detect eid_checker u_chk (
  .clk(clk), .rst(rst), .state_oh(state_oh), .first(stb_first),
  .req(req), .rdata(reg_rdata), .ack(ack), .reg_we(reg_we)
);

// File: tb/ext_irq_detect_bench.sv
`timescale 1ns/1ps
module ext_irq_detect_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] irq_n = 2'b11;
  logic [1:0] ack = 2'b00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] req;
  logic [5:0] state_oh;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_detect u_ext_irq_detect (
    .clk(clk), .rst(rst), .irq_n(irq_n), .ack(ack), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req), .state_oh(state_oh)
  );

  // reference model, advanced on every rising edge
  int       m_cnt = 0;
  bit [7:0] m_reg = 0;
  bit [1:0] m_lp = 0, m_ep = 0, m_prev = 2'b11;
  bit [1:0] pin_q[$] = '{2'b11, 2'b11};

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_reg = 0; m_lp = 0; m_ep = 0; m_prev = 2'b11;
      pin_q = '{2'b11, 2'b11};
    end else begin
      bit [1:0] seen;
      bit [7:0] nreg;
      seen = pin_q[0];
      nreg = reg_we ? (reg_wdata & 8'hF5) : (m_reg & 8'hF5);
      for (int ch = 0; ch < 2; ch++) begin
        bit v;
        bit edge_md;
        edge_md = m_reg[2*ch];
        v = reg_we ? reg_wdata[2*ch+1] : m_reg[2*ch+1];
        if (ack[ch]) v = 0;
        if (!edge_md && m_cnt == 10) v = 0;
        if (m_cnt == 4 && (edge_md ? m_ep[ch] : m_lp[ch])) v = 1;
        nreg[2*ch+1] = v;
      end
      if (m_cnt == 8) begin
        m_lp = ~seen;
        m_ep = m_prev & ~seen;
        m_prev = seen;
      end
      m_reg = nreg;
      pin_q.push_back(irq_n);
      void'(pin_q.pop_front());
      m_cnt = (m_cnt + 1) % 12;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 state", int'(state_oh), 1 << (m_cnt / 2));
      check("R3 rdata", int'(reg_rdata), int'(m_reg));
      check("R10 req", int'(req), int'({m_reg[3], m_reg[1]}));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input int n);
    @(negedge clk);
    while (m_cnt != n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    done = 1;
    finish_run();
  end

  initial begin
    bit [15:0] lfsr;
    tick(3);
    // R2 reset state
    check("R2 rdata", int'(reg_rdata), 0);
    check("R2 req", int'(req), 0);
    check("R2 state", int'(state_oh), 1);
    rst = 1'b0;

    // R1 sequence over one machine cycle
    wait_cnt(0);
    for (int i = 0; i < 12; i++) begin
      check("R1 order", int'(state_oh), 1 << (i / 2));
      tick(1);
    end

    // R3 plain bits store, layout
    wr(8'hFA);
    check("R3 stored bits", int'(reg_rdata & 8'hF5), 8'hF0);
    wr(8'h00);
    tick(2);
    check("R3 cleared", int'(reg_rdata), 0);

    // R5 / R6 level mode, pin 0 held low
    irq_n = 2'b10;
    tick(30);
    wait_cnt(8);
    check("R5 level set", int'(req), 1);
    wait_cnt(0);
    check("R6 level clear at S6", int'(req), 0);
    irq_n = 2'b11;
    tick(30);
    wait_cnt(8);
    check("R6 high pin no request", int'(req), 0);

    // R4 late fall is seen one machine cycle later
    wait_cnt(7);
    irq_n = 2'b10;
    wait_cnt(6);
    check("R4 late fall missed", int'(req[0]), 0);
    wait_cnt(6);
    check("R4 seen next cycle", int'(req[0]), 1);
    irq_n = 2'b11;
    tick(30);

    // R7 edge mode, pin 1 falls and stays low
    wr(8'h05);
    tick(30);
    irq_n = 2'b01;
    tick(40);
    check("R7 edge set", int'(req), 2);
    tick(30);
    check("R7 edge held", int'(req), 2);

    // R8 ack clears; held-low pin does not re-trigger
    ack = 2'b10; tick(1); ack = 2'b00;
    check("R8 ack clear", int'(req[1]), 0);
    tick(40);
    check("R8 no retrigger", int'(req[1]), 0);
    irq_n = 2'b11; tick(30);
    irq_n = 2'b01; tick(40);
    check("R7 second edge", int'(req[1]), 1);
    wr(8'h05);
    check("R8 write clear", int'(req[1]), 0);
    irq_n = 2'b11;
    tick(30);

    // R9 set at S3 wins over ack and write of 0 (level mode)
    wr(8'h00);
    irq_n = 2'b10;
    tick(30);
    wait_cnt(4);
    reg_we = 1'b1; reg_wdata = 8'h00; ack = 2'b01;
    tick(1);
    reg_we = 1'b0; ack = 2'b00;
    check("R9 set beats ack", int'(req[0]), 1);
    // S6 clear wins over a write of 1
    irq_n = 2'b11;
    wait_cnt(10);
    reg_we = 1'b1; reg_wdata = 8'h02;
    tick(1);
    reg_we = 1'b0;
    check("R9 clear beats write", int'(req[0]), 0);

    // pseudo-random stretch, checked by the model every clock
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq_n = lfsr[1:0];
      ack = (lfsr[7:4] == 4'h3) ? lfsr[9:8] : 2'b00;
      if (lfsr[15:12] == 4'h0) begin
        reg_we = 1'b1; reg_wdata = lfsr[11:4];
      end
      tick(1);
      reg_we = 1'b0; ack = 2'b00;
      tick(int'(lfsr[6:2]));
    end

    tick(2);
    done = 1;
    finish_run();
  end
endmodule